// File: doc/BRIEF.md
# Timestamped Sample Packet Framer

The framer takes a continuous stream of 32-bit complex samples (16-bit I, 16-bit Q), each offered together with its sample-clock timestamp. It packs them into fixed-size messages for a host transfer engine. Each message begins with a four-word, 16-byte header: a reserved word, the 64-bit timestamp of the first payload sample split into low and high words, and a flags word. The payload samples follow in order.

The link mode input selects the message size. High-speed mode uses a 2048-byte message, which holds 508 samples. Full-speed mode uses a 512-byte message, which holds 124 samples. The reserved and flags words come either from fixed defaults or from two configuration words. The selection, the words and the mode are all captured when a message starts.

If the downstream is not ready in the cycle a message would start, the framer takes in and discards every sample of that message. The next header then shows a timestamp jump that marks the overrun.

The controller has seven states:
- IDLE waits for a sample. When one is offered, it captures the header fields and moves to HDR0 if the output is ready, or to DROP if it is not.
- HDR0 to HDR3 send the four header words, each advancing on output ready.
- BODY passes samples through and returns to IDLE after the last one.
- DROP consumes one message's worth of samples and returns to IDLE after the last one.

Top module: `sample_framer`

## Requirements
- R1: During and right after reset (asynchronous, active low), `m_valid`, `s_ready`, `m_sof` and `m_eof` are 0.
- R2: Word 0 of every message is the reserved word, and it is the only word marked with `m_sof`=1.
- R3: Words 1 and 2 hold the timestamp T presented with the first payload sample, low 32 bits first, so that byte 4 of the message is T[7:0] (little-endian).
- R4: Word 3 is the flags word.
- R5: With `link_hs`=1 a message is 512 words (508 samples); with `link_hs`=0 it is 128 words (124 samples). `m_eof`=1 marks the last payload word only.
- R6: Payload words are the accepted samples, unchanged and in order. Sample n of a message carries timestamp T+n.
- R7: If `m_ready`=0 in the cycle a message would start, all of that message's samples are accepted and nothing is output for them. The next header's timestamp is larger by one message's worth of samples.
- R8: While `m_valid`=1 and `m_ready`=0, `m_valid` and `m_data` hold, and no sample is lost.
- R9: `link_hs`, `hdr_from_cfg`, `cfg_reserved` and `cfg_flags` are sampled when a message starts. Changes to them during that message have no effect on it.
- R10: With `hdr_from_cfg`=0 the reserved word is 0xFFFFFFFF and the flags word is 0x12344321. With `hdr_from_cfg`=1 they are `cfg_reserved` and `cfg_flags`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| link_hs | input | 1 | 1: high-speed message size, 0: full-speed |
| hdr_from_cfg | input | 1 | 1: header words from configuration, 0: defaults |
| cfg_reserved | input | 32 | Configured reserved word |
| cfg_flags | input | 32 | Configured flags word |
| ts_count | input | 64 | Timestamp of the sample currently offered |
| s_valid | input | 1 | Sample offered |
| s_ready | output | 1 | Sample accepted this cycle when both are high |
| s_data | input | 32 | Sample {Q, I} |
| m_valid | output | 1 | Output word valid |
| m_ready | input | 1 | Downstream accepts the word |
| m_data | output | 32 | Output word |
| m_sof | output | 1 | First word of a message |
| m_eof | output | 1 | Last word of a message |

## Verification
The hold and sequencing assertions assume a well-behaved source. Once it raises `s_valid`, it keeps `s_valid`, `s_data` and `ts_count` steady until the sample is accepted, because the framer forwards payload without storing it. The bench source withdraws or pauses a sample only in cycles after an acceptance, and its timestamp always tracks the index of the sample on offer. Output stalls are applied only after a message's first word has been taken, except in the overrun test, where the stall is aimed deliberately at the start cycle.

// File: rtl/frm_pkg.sv
package frm_pkg;
    typedef enum logic [2:0] {
        ST_IDLE, ST_HDR0, ST_HDR1, ST_HDR2, ST_HDR3, ST_BODY, ST_DROP
    } frm_state_t;

    typedef enum logic [1:0] {
        HSEL_RES, HSEL_TSLO, HSEL_TSHI, HSEL_FLG
    } hsel_t;
endpackage

// File: rtl/frm_counter.sv
module frm_counter #(
    parameter int HS_N = 508,
    parameter int FS_N = 124
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic mode,
    input  logic inc,
    output logic last
);
    localparam int CMAX = (HS_N > FS_N) ? HS_N : FS_N;
    localparam int CW   = $clog2(CMAX);

    logic [CW-1:0] cnt;
    logic [CW-1:0] lim_m1;
    logic          mode_q;

    assign lim_m1 = mode_q ? CW'(HS_N - 1) : CW'(FS_N - 1);
    assign last   = (cnt == lim_m1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt    <= '0;
            mode_q <= 1'b0;
        end else if (start) begin
            cnt    <= '0;
            mode_q <= mode;
        end else if (inc) begin
            cnt <= last ? '0 : cnt + 1'b1;
        end
    end

    // R5: sample index never passes the message length
    a_r5_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= lim_m1);
endmodule

// File: rtl/frm_header.sv
module frm_header
    import frm_pkg::*;
#(
    parameter int          DW      = 32,
    parameter int          TW      = 64,
    parameter logic [31:0] DEF_RES = 32'hFFFF_FFFF,
    parameter logic [31:0] DEF_FLG = 32'h1234_4321
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          use_cfg,
    input  logic [DW-1:0] cfg_res,
    input  logic [DW-1:0] cfg_flg,
    input  logic [TW-1:0] ts_in,
    input  hsel_t         sel,
    output logic [DW-1:0] word
);
    logic [DW-1:0] res_q, flg_q;
    logic [TW-1:0] ts_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
            flg_q <= '0;
            ts_q  <= '0;
        end else if (start) begin
            res_q <= use_cfg ? cfg_res : DW'(DEF_RES);
            flg_q <= use_cfg ? cfg_flg : DW'(DEF_FLG);
            ts_q  <= ts_in;
        end
    end

    always_comb begin
        unique case (sel)
            HSEL_RES:  word = res_q;
            HSEL_TSLO: word = ts_q[DW-1:0];
            HSEL_TSHI: word = ts_q[2*DW-1:DW];
            HSEL_FLG:  word = flg_q;
            default:   word = res_q;
        endcase
    end
endmodule

// File: rtl/frm_fsm.sv
module frm_fsm
    import frm_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  s_valid,
    input  logic  m_ready,
    input  logic  last,
    output logic  start,
    output logic  s_ready,
    output logic  m_valid,
    output logic  m_sof,
    output logic  m_eof,
    output logic  inc,
    output logic  pass,
    output hsel_t hsel
);
    frm_state_t state, nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt     = state;
        start   = 1'b0;
        s_ready = 1'b0;
        m_valid = 1'b0;
        m_sof   = 1'b0;
        m_eof   = 1'b0;
        inc     = 1'b0;
        pass    = 1'b0;
        hsel    = HSEL_RES;
        unique case (state)
            ST_IDLE: begin
                if (s_valid) begin
                    start = 1'b1;
                    nxt   = m_ready ? ST_HDR0 : ST_DROP;
                end
            end
            ST_HDR0: begin
                m_valid = 1'b1;
                m_sof   = 1'b1;
                hsel    = HSEL_RES;
                if (m_ready) nxt = ST_HDR1;
            end
            ST_HDR1: begin
                m_valid = 1'b1;
                hsel    = HSEL_TSLO;
                if (m_ready) nxt = ST_HDR2;
            end
            ST_HDR2: begin
                m_valid = 1'b1;
                hsel    = HSEL_TSHI;
                if (m_ready) nxt = ST_HDR3;
            end
            ST_HDR3: begin
                m_valid = 1'b1;
                hsel    = HSEL_FLG;
                if (m_ready) nxt = ST_BODY;
            end
            ST_BODY: begin
                pass    = 1'b1;
                m_valid = s_valid;
                s_ready = m_ready;
                m_eof   = s_valid && last;
                inc     = s_valid && m_ready;
                if (s_valid && m_ready && last) nxt = ST_IDLE;
            end
            ST_DROP: begin
                s_ready = 1'b1;
                inc     = s_valid;
                if (s_valid && last) nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // R2: the header continues without a bubble and without a second start mark
    a_r2_sof_seq: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && m_sof && m_ready) |=> (m_valid && !m_sof));
    // R7: a start seen while the output is blocked produces no output word
    a_r7_drop_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !m_ready) |=> !m_valid);
    // R5: after the last word the framer returns to waiting
    a_r5_eof_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && m_eof && m_ready) |=> (!m_valid && !s_ready));
    // R2, R5: start and end marks never coincide
    a_r5_marks_apart: assert property (@(posedge clk) disable iff (!rst_n)
        !(m_sof && m_eof));
endmodule

// File: rtl/sample_framer.sv
module sample_framer
    import frm_pkg::*;
#(
    parameter int DW       = 32,
    parameter int TW       = 64,
    parameter int HDR_B    = 16,
    parameter int SMP_B    = 4,
    parameter int HS_MSG_B = 2048,
    parameter int FS_MSG_B = 512
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          link_hs,
    input  logic          hdr_from_cfg,
    input  logic [DW-1:0] cfg_reserved,
    input  logic [DW-1:0] cfg_flags,
    input  logic [TW-1:0] ts_count,
    input  logic          s_valid,
    output logic          s_ready,
    input  logic [DW-1:0] s_data,
    output logic          m_valid,
    input  logic          m_ready,
    output logic [DW-1:0] m_data,
    output logic          m_sof,
    output logic          m_eof
);
    localparam int HS_N = (HS_MSG_B - HDR_B) / SMP_B;
    localparam int FS_N = (FS_MSG_B - HDR_B) / SMP_B;

    logic          start, inc, pass, last;
    hsel_t         hsel;
    logic [DW-1:0] hdr_word;

    frm_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .s_valid (s_valid),
        .m_ready (m_ready),
        .last    (last),
        .start   (start),
        .s_ready (s_ready),
        .m_valid (m_valid),
        .m_sof   (m_sof),
        .m_eof   (m_eof),
        .inc     (inc),
        .pass    (pass),
        .hsel    (hsel)
    );

    frm_counter #(.HS_N(HS_N), .FS_N(FS_N)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .mode  (link_hs),
        .inc   (inc),
        .last  (last)
    );

    frm_header #(.DW(DW), .TW(TW)) u_hdr (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .use_cfg (hdr_from_cfg),
        .cfg_res (cfg_reserved),
        .cfg_flg (cfg_flags),
        .ts_in   (ts_count),
        .sel     (hsel),
        .word    (hdr_word)
    );

    assign m_data = pass ? s_data : hdr_word;

    // R8: a stalled output word stays offered and unchanged
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && !m_ready) |=> (m_valid && $stable(m_data)));
    // R1: nothing is offered or accepted in the first cycle out of reset
    a_r1_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!m_valid && !s_ready));
endmodule

// File: tb/sample_framer_test.sv
`timescale 1ns/1ps
module sample_framer_test;
    localparam logic [63:0] TS_OFF = 64'h0000_0001_FFFF_FE00;
    localparam int HS_N = 508;
    localparam int FS_N = 124;
    // {link_hs, hdr_from_cfg, gap, bp, reserved, flags}
    localparam int NV = 5;
    localparam logic [67:0] VEC [0:NV-1] = '{
        {1'b1, 1'b0, 1'b0, 1'b0, 32'h0000_0000, 32'h0000_0000},
        {1'b0, 1'b1, 1'b0, 1'b0, 32'hDEAD_BEEF, 32'h00C0_FFEE},
        {1'b1, 1'b1, 1'b1, 1'b1, 32'h0123_4567, 32'h89AB_CDEF},
        {1'b0, 1'b0, 1'b1, 1'b0, 32'h0000_0000, 32'h0000_0000},
        {1'b0, 1'b1, 1'b0, 1'b1, 32'hA5A5_5A5A, 32'h0F0F_0F0F}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        link_hs = 1'b1, hdr_from_cfg = 1'b0;
    logic [31:0] cfg_reserved = '0, cfg_flags = '0;
    logic [63:0] ts_count;
    logic        s_valid = 1'b0, s_ready;
    logic [31:0] s_data;
    logic        m_valid, m_ready = 1'b1;
    logic [31:0] m_data;
    logic        m_sof, m_eof;

    sample_framer uut (
        .clk(clk), .rst_n(rst_n), .link_hs(link_hs), .hdr_from_cfg(hdr_from_cfg),
        .cfg_reserved(cfg_reserved), .cfg_flags(cfg_flags), .ts_count(ts_count),
        .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
        .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data),
        .m_sof(m_sof), .m_eof(m_eof)
    );

    always #2.5 clk = ~clk;

    int          n_checks = 0, n_fail = 0;
    bit          done = 0;
    int unsigned sidx = 0;
    logic [31:0] cap_d [0:1023];
    bit          cap_s [0:1023];
    bit          cap_e [0:1023];
    int          ncap;
    bit          prev_stall = 0;
    logic [31:0] prev_data;
    int          hold_err = 0;
    bit          pending = 0;

    function automatic logic [31:0] smp(int unsigned i);
        return {~i[15:0], i[15:0]};
    endfunction

    task automatic drive_src();
        s_data   = smp(sidx);
        ts_count = TS_OFF + 64'(sidx);
    endtask

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one clock: settle, observe the handshakes of the coming edge, advance
    task automatic step();
        bit src_hs;
        drive_src();
        #1;
        src_hs = s_valid && s_ready && rst_n;
        if (prev_stall && rst_n && (!m_valid || m_data !== prev_data)) hold_err++;
        if (m_valid && m_ready && rst_n && ncap < 1024) begin
            cap_d[ncap] = m_data;
            cap_s[ncap] = m_sof;
            cap_e[ncap] = m_eof;
            ncap++;
        end
        prev_stall = m_valid && !m_ready && rst_n;
        prev_data  = m_data;
        pending    = s_valid && !src_hs;
        @(posedge clk);
        #1;
        if (src_hs) sidx++;
    endtask

    // next source valid: never withdraw an offered, unaccepted sample
    function automatic logic src_v(bit gap, int cyc);
        return pending ? 1'b1 : !(gap && (cyc % 5 == 2));
    endfunction

    task automatic run_msg(bit hs, bit use_c, bit gap, bit bp,
                           logic [31:0] res, logic [31:0] flg,
                           bit chg, int unsigned skip);
        int unsigned st, n;
        logic [63:0] t;
        logic [31:0] er, ef;
        int cyc, bad, mk;
        bit got_eof;
        link_hs = hs; hdr_from_cfg = use_c; cfg_reserved = res; cfg_flags = flg;
        st = sidx + skip;
        n  = hs ? HS_N : FS_N;
        t  = TS_OFF + 64'(st);
        er = use_c ? res : 32'hFFFF_FFFF;
        ef = use_c ? flg : 32'h1234_4321;
        ncap = 0; got_eof = 0; cyc = 0; hold_err = 0;
        while (!got_eof && cyc < 5000) begin
            s_valid = src_v(gap, cyc);
            m_ready = !(bp && ncap > 0 && (cyc % 3 == 0));
            if (chg && ncap > 0) begin
                cfg_reserved = ~res; cfg_flags = 32'h0;
                link_hs = ~hs; hdr_from_cfg = ~use_c;
            end
            step();
            if (ncap > 0 && cap_e[ncap-1]) got_eof = 1;
            cyc++;
        end
        m_ready = 1'b1;
        check("R5 message completes", 64'(got_eof), 64'd1);
        check("R2 word0 reserved", 64'(cap_d[0]), 64'(er));
        check("R3 word1 ts low", 64'(cap_d[1]), 64'(t[31:0]));
        check("R3 word2 ts high", 64'(cap_d[2]), 64'(t[63:32]));
        check(use_c ? "R4 word3 flags" : "R10 word3 default flags",
              64'(cap_d[3]), 64'(ef));
        check("R5 message length", 64'(ncap), 64'(n + 4));
        bad = 0; mk = 0;
        for (int i = 0; i < ncap && i < 1024; i++) begin
            if (cap_s[i] != (i == 0)) mk++;
            if (cap_e[i] != (i == ncap - 1)) mk++;
            if (i >= 4 && cap_d[i] !== smp(st + i - 4)) bad++;
        end
        check("R5 sof/eof mark errors", 64'(mk), 64'd0);
        check("R6 payload mismatches", 64'(bad), 64'd0);
        check("R8 hold violations", 64'(hold_err), 64'd0);
    endtask

    initial begin
        #900000;
        if (!done) begin
            n_fail++; n_checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        drive_src();
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset m_valid", 64'(m_valid), 64'd0);
        check("R1 reset s_ready", 64'(s_ready), 64'd0);
        check("R1 reset marks", 64'({m_sof, m_eof}), 64'd0);
        rst_n = 1'b1;
        @(posedge clk); #1;

        for (int v = 0; v < NV; v++)
            run_msg(VEC[v][67], VEC[v][66], VEC[v][65], VEC[v][64],
                    VEC[v][63:32], VEC[v][31:0], 1'b0, 0);

        // R7: output blocked at the start cycle drops one full message
        link_hs = 1'b1; hdr_from_cfg = 1'b0;
        s_valid = 1'b1; m_ready = 1'b0;
        ncap = 0;
        step();
        m_ready = 1'b1;
        run_msg(1'b1, 1'b0, 1'b0, 1'b0, 32'h0, 32'h0, 1'b0, HS_N);
        check("R7 no output from dropped message", 64'(cap_s[0]), 64'd1);

        // R9: configuration changes inside a message are ignored
        run_msg(1'b0, 1'b1, 1'b1, 1'b1, 32'h5555_AAAA, 32'h3C3C_C3C3, 1'b1, 0);

        // R1: reset in the middle of a message
        link_hs = 1'b1; s_valid = 1'b1; ncap = 0;
        repeat (20) step();
        rst_n = 1'b0;
        #1;
        check("R1 mid-message reset m_valid", 64'(m_valid), 64'd0);
        check("R1 mid-message reset s_ready", 64'(s_ready), 64'd0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        pending = 0;
        run_msg(1'b0, 1'b1, 1'b0, 1'b0, 32'h1111_2222, 32'h3333_4444, 1'b0, 0);

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule